// File: doc/BRIEF.md
# Power-Good Deglitch Monitor

This block turns the digital flags of a regulator's feedback comparators into a qualified power-good indication. One flag says the feedback voltage sits above the upper threshold (92.5% of the reference), another says it sits below the lower threshold (90% of the reference), and a third says the reference itself is above its minimum valid level (0.54 V). Three fault indications cover shutdown, supply undervoltage lockout and thermal shutdown. The single output, `pg_release`, is high when the external open-drain power-good device may be released and low when it must pull down.

Each direction of change has its own qualifying condition, and that condition must hold without a break for a parameterised number of clock cycles (48 by default) before the output moves. Feedback between the two thresholds leaves the output where it is, which gives hysteresis. Any fault drives the output low in the same cycle, bypassing the deglitch counter, and also clears the counter, so a fresh full qualification window is needed once the fault is gone.

Top module: `pgdm_monitor`

## Requirements
- R1: With no fault, the output rises only after the release condition (`fb_above_hi` = 1 and `ref_valid` = 1) has been sampled true on DEGLITCH_CYCLES consecutive rising clock edges; it is high right after the last of those edges and low right after the one before it.
- R2: With no fault and the output high, the output falls only after the drop condition (`fb_below_lo` = 1 or `ref_valid` = 0) has been sampled true on DEGLITCH_CYCLES consecutive rising edges.
- R3: With `ref_valid` = 1 and both feedback flags at 0 (feedback inside the hysteresis band), the output keeps its current level for any number of cycles, high or low.
- R4: While any of `shutdown`, `uvlo` or `thermal_fault` is 1 the output is 0 in the same cycle, without waiting for a clock edge.
- R5: If the pending condition drops out for one or more edges before the count completes, the count restarts: a further full DEGLITCH_CYCLES edges are needed.
- R6: During reset and immediately after reset release the output is 0.
- R7: After a fault clears, the output stays 0 until the release condition has held for DEGLITCH_CYCLES consecutive edges with no fault, even if feedback was above the upper threshold throughout the fault.
- R8: With `fb_above_hi` = 1 but `ref_valid` = 0 the output never rises, and an invalid reference alone is enough to pull a high output low after the deglitch window.

Top module port list below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_above_hi | input | 1 | Feedback above upper threshold (92.5% of reference) |
| fb_below_lo | input | 1 | Feedback below lower threshold (90% of reference) |
| ref_valid | input | 1 | Reference above its minimum valid level |
| shutdown | input | 1 | Regulator shut down |
| uvlo | input | 1 | Supply undervoltage lockout active |
| thermal_fault | input | 1 | Thermal shutdown active |
| pg_release | output | 1 | 1 = release the open-drain power-good output, 0 = pull low |

## Verification
The hardest situations to reach from the ports are the exact edges of the deglitch window: a condition that breaks on its 47th edge, a fault that appears for one cycle in the middle of a nearly completed count, and a release condition that was already true while a fault was active. Plain random flags almost never hold steady for 48 edges, so the stimulus picks a flag pattern and holds it for a random run length around the window size, with short fault pulses injected at random, and a set of directed sequences places breaks and faults at counts 47 and 48 explicitly.

// File: rtl/pgdm_pkg.sv
package pgdm_pkg;

  // Level of the qualified power-good state
  typedef enum logic {
    PG_LOW  = 1'b0,
    PG_HIGH = 1'b1
  } pg_state_e;

endpackage

// File: rtl/pgdm_qualify.sv
// Combines comparator flags and faults into the condition that the
// deglitch counter should time for the transition now pending.
module pgdm_qualify
  import pgdm_pkg::*;
(
  input  pg_state_e state,
  input  logic      fb_above_hi,
  input  logic      fb_below_lo,
  input  logic      ref_valid,
  input  logic      shutdown,
  input  logic      uvlo,
  input  logic      thermal_fault,
  output logic      fault,
  output logic      pend_cond
);

  logic rise_ok;
  logic drop_ok;

  always_comb begin
    fault   = shutdown | uvlo | thermal_fault;
    rise_ok = fb_above_hi & ref_valid;
    drop_ok = fb_below_lo | ~ref_valid;
    if (state == PG_HIGH) begin
      pend_cond = drop_ok;
    end else begin
      pend_cond = rise_ok;
    end
  end

endmodule

// File: rtl/pgdm_counter.sv
// Consecutive-cycle counter; done pulses on the edge that completes
// DEGLITCH_CYCLES uninterrupted qualifying samples.
module pgdm_counter #(
  parameter int DEGLITCH_CYCLES = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic done
);

  localparam int CNT_W = (DEGLITCH_CYCLES > 1) ? $clog2(DEGLITCH_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEGLITCH_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    done  = 1'b0;
    cnt_d = cnt_q;
    if (clr || !adv) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
      done  = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/pgdm_monitor.sv
// Power-good deglitch monitor top level.
module pgdm_monitor
  import pgdm_pkg::*;
#(
  parameter int DEGLITCH_CYCLES = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fb_above_hi,
  input  logic fb_below_lo,
  input  logic ref_valid,
  input  logic shutdown,
  input  logic uvlo,
  input  logic thermal_fault,
  output logic pg_release
);

  pg_state_e state_q;
  pg_state_e state_d;
  logic      fault;
  logic      pend_cond;
  logic      win_done;

  pgdm_qualify u_qual (
    .state         (state_q),
    .fb_above_hi   (fb_above_hi),
    .fb_below_lo   (fb_below_lo),
    .ref_valid     (ref_valid),
    .shutdown      (shutdown),
    .uvlo          (uvlo),
    .thermal_fault (thermal_fault),
    .fault         (fault),
    .pend_cond     (pend_cond)
  );

  pgdm_counter #(
    .DEGLITCH_CYCLES (DEGLITCH_CYCLES)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fault),
    .adv   (pend_cond),
    .done  (win_done)
  );

  // Next state: faults win, otherwise toggle when a window completes
  always_comb begin
    state_d = state_q;
    if (fault) begin
      state_d = PG_LOW;
    end else if (win_done) begin
      state_d = (state_q == PG_HIGH) ? PG_LOW : PG_HIGH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PG_LOW;
    end else begin
      state_q <= state_d;
    end
  end

  // Fault override acts combinationally, bypassing the counter
  assign pg_release = (state_q == PG_HIGH) && !fault;

endmodule

// File: rtl/pgdm_checker.sv
// Protocol checker attached to pgdm_monitor.
module pgdm_checker #(
  parameter int DEGLITCH_CYCLES = 48
) (
  input logic clk,
  input logic rst_n,
  input logic fb_above_hi,
  input logic fb_below_lo,
  input logic ref_valid,
  input logic shutdown,
  input logic uvlo,
  input logic thermal_fault,
  input logic pg_release
);

  localparam int RUN_W = $clog2(DEGLITCH_CYCLES + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(DEGLITCH_CYCLES);

  logic             flt;
  logic [RUN_W-1:0] run_up;
  logic [RUN_W-1:0] run_dn;
  logic             seen_edge;

  assign flt = shutdown | uvlo | thermal_fault;

  // Consecutive-edge run lengths of each qualifying condition
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_up    <= '0;
      run_dn    <= '0;
      seen_edge <= 1'b0;
    end else begin
      seen_edge <= 1'b1;
      if (fb_above_hi && ref_valid && !flt) begin
        run_up <= (run_up == RUN_MAX) ? run_up : run_up + 1'b1;
      end else begin
        run_up <= '0;
      end
      if ((fb_below_lo || !ref_valid) && !flt) begin
        run_dn <= (run_dn == RUN_MAX) ? run_dn : run_dn + 1'b1;
      end else begin
        run_dn <= '0;
      end
    end
  end

  // R1, R5, R7, R8: a rise needs a full uninterrupted release window
  a_r1_rise_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_release) |-> (run_up == RUN_MAX));

  // R2: a fall without a fault needs a full drop window
  a_r2_fall_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pg_release) && !flt) |-> (run_dn == RUN_MAX));

  // R4: any fault holds the output low
  a_r4_fault_low: assert property (@(posedge clk) disable iff (!rst_n)
    flt |-> !pg_release);

  // R6: output low on the first edge after reset release
  a_r6_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_edge |-> !pg_release);

  // R3: inside the band with a valid reference and no fault, no change
  a_r3_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_edge && $past(ref_valid && !fb_above_hi && !fb_below_lo && !flt) && !flt)
      |-> $stable(pg_release));

endmodule

bind pgdm_monitor pgdm_checker #(
  .DEGLITCH_CYCLES (DEGLITCH_CYCLES)
) u_pgdm_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fb_above_hi   (fb_above_hi),
  .fb_below_lo   (fb_below_lo),
  .ref_valid     (ref_valid),
  .shutdown      (shutdown),
  .uvlo          (uvlo),
  .thermal_fault (thermal_fault),
  .pg_release    (pg_release)
);

// File: tb/test_pgdm_monitor.sv
module test_pgdm_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 48;

  logic clk;
  logic rst_n;
  logic fb_above_hi;
  logic fb_below_lo;
  logic ref_valid;
  logic shutdown;
  logic uvlo;
  logic thermal_fault;
  logic pg_release;

  int checks;
  int errors;
  bit done_flag;

  // Reference model state
  bit m_q;
  int m_cnt;

  pgdm_monitor #(.DEGLITCH_CYCLES(N)) i_pgdm_monitor (
    .clk           (clk),
    .rst_n         (rst_n),
    .fb_above_hi   (fb_above_hi),
    .fb_below_lo   (fb_below_lo),
    .ref_valid     (ref_valid),
    .shutdown      (shutdown),
    .uvlo          (uvlo),
    .thermal_fault (thermal_fault),
    .pg_release    (pg_release)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit any_fault();
    return shutdown | uvlo | thermal_fault;
  endfunction

  // Condition that the requirements say is being timed right now
  function automatic bit model_cond(bit q);
    if (q) return fb_below_lo | ~ref_valid;
    return fb_above_hi & ref_valid;
  endfunction

  function automatic bit model_out();
    return m_q & ~any_fault();
  endfunction

  task automatic check(string req, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pg_release=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(bit hi, bit lo, bit rv, bit sd, bit uv, bit tf);
    fb_above_hi   = hi;
    fb_below_lo   = lo;
    ref_valid     = rv;
    shutdown      = sd;
    uvlo          = uv;
    thermal_fault = tf;
  endtask

  // One clock edge: advance the model from the pre-edge inputs,
  // then compare shortly after the edge.
  task automatic tick(string req);
    if (any_fault()) begin
      m_q   = 1'b0;
      m_cnt = 0;
    end else if (model_cond(m_q)) begin
      if (m_cnt == N - 1) begin
        m_q   = ~m_q;
        m_cnt = 0;
      end else begin
        m_cnt++;
      end
    end else begin
      m_cnt = 0;
    end
    @(posedge clk);
    #1;
    check(req, pg_release, model_out());
  endtask

  task automatic ticks(int n, string req);
    for (int i = 0; i < n; i++) tick(req);
  endtask

  // Bring output high from a known state
  task automatic go_high();
    drive(1, 0, 1, 0, 0, 0);
    ticks(N + 2, "R1");
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog: pg_release=%0b expected completion", pg_release);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5EED_1234));
    checks = 0; errors = 0; done_flag = 0;
    m_q = 0; m_cnt = 0;
    rst_n = 1'b0;
    drive(1, 0, 1, 0, 0, 0);
    #(CLK_PERIOD * 3 + 1);
    check("R6", pg_release, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    tick("R6");
    check("R6", pg_release, 1'b0);

    // R1: exact window; already one edge counted above
    ticks(N - 2, "R1");
    check("R1", pg_release, 1'b0);
    tick("R1");
    check("R1", pg_release, 1'b1);

    // R3: in-band hold while high
    drive(0, 0, 1, 0, 0, 0);
    ticks(200, "R3");
    check("R3", pg_release, 1'b1);

    // R5: drop condition for N-1 edges, then a break, then N-1 again
    drive(0, 1, 1, 0, 0, 0);
    ticks(N - 1, "R5");
    drive(0, 0, 1, 0, 0, 0);
    tick("R5");
    drive(0, 1, 1, 0, 0, 0);
    ticks(N - 1, "R5");
    check("R5", pg_release, 1'b1);
    tick("R2");
    check("R2", pg_release, 1'b0);

    // R3: in-band hold while low
    drive(0, 0, 1, 0, 0, 0);
    ticks(200, "R3");
    check("R3", pg_release, 1'b0);

    // R8: feedback high but reference invalid never releases
    drive(1, 0, 0, 0, 0, 0);
    ticks(3 * N, "R8");
    check("R8", pg_release, 1'b0);

    // R8: reference invalid alone pulls a high output low
    go_high();
    drive(1, 0, 0, 0, 0, 0);
    ticks(N - 1, "R8");
    check("R8", pg_release, 1'b1);
    tick("R8");
    check("R8", pg_release, 1'b0);

    // R4: each fault forces low at once, without a clock edge
    go_high();
    for (int f = 0; f < 3; f++) begin
      @(negedge clk);
      drive(1, 0, 1, f == 0, f == 1, f == 2);
      #1;
      check("R4", pg_release, 1'b0);
      tick("R4");
      // R7: after the fault clears, low until a full window
      drive(1, 0, 1, 0, 0, 0);
      ticks(N - 1, "R7");
      check("R7", pg_release, 1'b0);
      tick("R7");
      check("R7", pg_release, 1'b1);
    end

    // R7: one-cycle fault inside a nearly complete rise window
    drive(0, 1, 1, 0, 0, 0);
    ticks(N, "R2");
    drive(1, 0, 1, 0, 0, 0);
    ticks(N - 1, "R7");
    drive(1, 0, 1, 0, 1, 0);
    tick("R7");
    drive(1, 0, 1, 0, 0, 0);
    ticks(N - 1, "R7");
    check("R7", pg_release, 1'b0);
    tick("R7");
    check("R7", pg_release, 1'b1);

    // Constrained random: held patterns with fault pulses
    for (int blk = 0; blk < 600; blk++) begin
      int run;
      int pat;
      pat = int'($urandom_range(0, 5));
      run = int'($urandom_range(1, N + 20));
      case (pat)
        0: drive(1, 0, 1, 0, 0, 0);
        1: drive(0, 1, 1, 0, 0, 0);
        2: drive(0, 0, 1, 0, 0, 0);
        3: drive(1, 0, 0, 0, 0, 0);
        4: drive(0, 0, 0, 0, 0, 0);
        default: drive($urandom_range(0, 1), $urandom_range(0, 1), 1, 0, 0, 0);
      endcase
      for (int c = 0; c < run; c++) begin
        if ($urandom_range(0, 99) < 2) begin
          shutdown      = $urandom_range(0, 1);
          uvlo          = $urandom_range(0, 1);
          thermal_fault = ~(shutdown | uvlo);
        end else begin
          shutdown = 0; uvlo = 0; thermal_fault = 0;
        end
        if (any_fault()) tick("R4");
        else if (m_q) tick("R2");
        else tick("R1");
      end
    end

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule